// File: doc/BRIEF.md
# Warm-Up Gated Capture and Voting Controller

This controller turns a bank of free-running delay-line oscillators into one stable response word. A start pulse in idle arrives once the challenge source has finished. The controller then switches the oscillator bank on and watches a single reference oscillator. It counts that oscillator's rising edges in the system clock domain until a warm-up limit is reached. At that point it opens a one-count capture window, copies the bank outputs, and switches the bank off again.

The enable, warm-up and capture cycle repeats an odd number of times, three by default. Each capture goes into its own sample register. A per-bit majority over the samples gives an intermediate word. That word is XORed with a random vector supplied from outside, which whitens it into the final response. The response comes with a one-cycle valid pulse.

The oscillators themselves sit outside this block. The controller only sees their enable, the tapped reference output and the sampled bank outputs.

Top module: `osc_vote_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `osc_en`, `latch_en` and `resp_valid` are 0 and `resp` is all zeros.
- R2: `osc_en` goes high in the clock cycle after a `start` sampled high in idle. It is never high before a start has been accepted.
- R3: While `osc_en` is high, the block counts rising edges of `ref_osc` after a two-flop synchronizer. Falling edges are not counted. `latch_en` rises once the count reaches `WARM_THR` (default 253), and only while `osc_en` is high.
- R4: The next rising edge, count `WARM_THR`+1, closes the window. `latch_en` and `osc_en` both fall together, and the edge counter restarts from zero for the next round.
- R5: One capture runs exactly `ROUNDS` enable periods, where `ROUNDS` = 2*`EXTRA_PAIRS`+1 (3 by default). Between periods `osc_en` is low for at least one cycle. Round k stores the `osc_bits` value present during its capture window into sample register k.
- R6: Each bit of the intermediate word is 1 exactly when more than half of the samples have a 1 in that bit. For three samples this is the 2-of-3 majority.
- R7: `resp` is loaded with the intermediate word XOR `rand_vec` when the last round ends. `resp_valid` is high for exactly one cycle, in the cycle where the new `resp` first shows. `resp` does not change at any other time, and `osc_en` is low while `resp_valid` is high.
- R8: A `start` pulse that arrives while a capture is under way has no effect. The running capture still has `ROUNDS` enable periods and gives one correct response.
- R9: Edges on `ref_osc` while the controller is idle have no effect. No enable, window or response comes from them.
- R10: The response width is `RESP_W` bits, 120 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a capture; accepted only in idle |
| ref_osc | input | 1 | Tapped reference oscillator output, asynchronous |
| osc_bits | input | RESP_W | Outputs of the oscillator bank |
| rand_vec | input | RESP_W | Whitening vector, sampled when the last round ends |
| osc_en | output | 1 | Oscillator bank enable |
| latch_en | output | 1 | Capture window, one warm-up count wide |
| resp | output | RESP_W | Whitened majority response |
| resp_valid | output | 1 | One-cycle strobe marking a new response |

## Verification
Any fault in the edge counter or the synchronizer moves the capture window. That shows up at the first `latch_en` rise as an edge count other than the threshold, well inside the first round. A wrong round counter or missed gap changes how many times `osc_en` rises before `resp_valid`, and a mis-steered sample register corrupts `resp`. Both are visible on the very first capture. The bench feeds each round a different bank pattern so that a sample landing in the wrong register changes the voted bits.

// File: rtl/osc_vote_pkg.sv
package osc_vote_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARM = 2'd1,
        PH_GAP  = 2'd2,
        PH_VOTE = 2'd3
    } phase_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic rise
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], raw};
    end

    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/osc_warm_cnt.sv
module osc_warm_cnt #(
    parameter int unsigned THR = 253,
    parameter int unsigned CW  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic at_thr,
    output logic close
);
    logic [CW-1:0] cnt_q;

    assign at_thr = run && (cnt_q == CW'(THR));
    assign close  = at_thr && tick;

    always_ff @(posedge clk) begin
        if (rst || !run || close) cnt_q <= '0;
        else if (tick)            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/osc_majority.sv
module osc_majority #(
    parameter int unsigned W = 120,
    parameter int unsigned N = 3
) (
    input  logic [N-1:0][W-1:0] samp,
    output logic [W-1:0]        maj
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [N-1:0] col;
        for (genvar r = 0; r < N; r++) begin : g_rnd
            assign col[r] = samp[r][b];
        end
        assign maj[b] = ($countones(col) > (N / 2));
    end
endmodule

// File: rtl/osc_vote_ctrl.sv
module osc_vote_ctrl
    import osc_vote_pkg::*;
#(
    parameter int unsigned RESP_W      = 120,
    parameter int unsigned WARM_THR    = 253,
    parameter int unsigned EXTRA_PAIRS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ref_osc,
    input  logic [RESP_W-1:0] osc_bits,
    input  logic [RESP_W-1:0] rand_vec,
    output logic              osc_en,
    output logic              latch_en,
    output logic [RESP_W-1:0] resp,
    output logic              resp_valid
);
    localparam int unsigned ROUNDS = 2 * EXTRA_PAIRS + 1;
    localparam int unsigned RW     = idx_bits(ROUNDS);
    localparam int unsigned CW     = $clog2(WARM_THR + 1);

    phase_e                        ph_q;
    logic [RW-1:0]                 rnd_q;
    logic [ROUNDS-1:0][RESP_W-1:0] samp_q;
    logic [RESP_W-1:0]             maj;
    logic                          tick;
    logic                          at_thr;
    logic                          close;

    assign osc_en   = (ph_q == PH_WARM);
    assign latch_en = at_thr;

    osc_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (ref_osc),
        .rise (tick)
    );

    osc_warm_cnt #(.THR(WARM_THR), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (osc_en),
        .tick   (tick),
        .at_thr (at_thr),
        .close  (close)
    );

    osc_majority #(.W(RESP_W), .N(ROUNDS)) u_vote (
        .samp (samp_q),
        .maj  (maj)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            rnd_q      <= '0;
            resp       <= '0;
            resp_valid <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_WARM;
                    rnd_q <= '0;
                end
                PH_WARM: if (close) begin
                    ph_q <= (rnd_q == RW'(ROUNDS - 1)) ? PH_VOTE : PH_GAP;
                end
                PH_GAP: begin
                    ph_q  <= PH_WARM;
                    rnd_q <= rnd_q + 1'b1;
                end
                default: begin
                    resp       <= maj ^ rand_vec;
                    resp_valid <= 1'b1;
                    ph_q       <= PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
        end else begin
            for (int r = 0; r < ROUNDS; r++) begin
                if (latch_en && rnd_q == RW'(r)) samp_q[r] <= osc_bits;
            end
        end
    end
endmodule

// File: rtl/osc_vote_chk.sv
module osc_vote_chk #(
    parameter int unsigned RESP_W = 120,
    parameter int unsigned ROUNDS = 3,
    parameter int unsigned RW     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              osc_en,
    input logic              latch_en,
    input logic              resp_valid,
    input logic [RESP_W-1:0] resp,
    input logic [RW-1:0]     rnd
);
    p_window_gated_r3: assert property (@(posedge clk) disable iff (rst)
        latch_en |-> osc_en);

    p_enable_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> ($past(start) || rnd != '0));

    p_close_drops_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_en) |-> !osc_en);

    p_strobe_width_r7: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    p_strobe_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !osc_en);

    p_resp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(resp) |-> resp_valid);

    p_round_range_r5: assert property (@(posedge clk) disable iff (rst)
        int'(rnd) < ROUNDS);
endmodule

bind osc_vote_ctrl osc_vote_chk #(
    .RESP_W (RESP_W),
    .ROUNDS (ROUNDS),
    .RW     (RW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .osc_en     (osc_en),
    .latch_en   (latch_en),
    .resp_valid (resp_valid),
    .resp       (resp),
    .rnd        (rnd_q)
);

// File: tb/osc_vote_ctrl_tb_top.sv
module osc_vote_ctrl_tb_top;
    localparam int W    = 120;
    localparam int THR  = 253;
    localparam int HALF = 4;
    localparam int NVEC = 5;

    localparam logic [W-1:0] VEC [NVEC][4] = '{
        '{{W{1'b0}},     {W{1'b0}},     {W{1'b0}},     {W{1'b0}}},
        '{{W{1'b1}},     {W{1'b1}},     {W{1'b0}},     {W{1'b0}}},
        '{{30{4'hA}},    {30{4'h5}},    {W{1'b1}},     {W{1'b0}}},
        '{{30{4'hA}},    {30{4'h5}},    {W{1'b0}},     {15{8'hF0}}},
        '{{10{12'h9C3}}, {10{12'h36A}}, {8{15'h2B71}}, {12{10'h2D5}}}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         ref_osc = 1'b0;
    logic [W-1:0] osc_bits = '0;
    logic [W-1:0] rand_vec = '0;
    logic         osc_en, latch_en, resp_valid;
    logic [W-1:0] resp;

    int nchk = 0, nfail = 0;
    int edge_cnt = 0, ph = 0;
    bit en_prev = 0, wiggle = 0, m_en = 0, m_lat = 0;
    int en_rises = 0, latch_rises = 0, vld_pulses = 0, pidx = 0;
    logic [W-1:0] pat [3];

    osc_vote_ctrl #(.RESP_W(W), .WARM_THR(THR), .EXTRA_PAIRS(1)) dut_i (
        .clk(clk), .rst(rst), .start(start), .ref_osc(ref_osc),
        .osc_bits(osc_bits), .rand_vec(rand_vec), .osc_en(osc_en),
        .latch_en(latch_en), .resp(resp), .resp_valid(resp_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Oscillator model: rising edge every 2*HALF cycles while enabled.
    initial begin
        forever begin
            @(posedge clk); #3;
            if (osc_en) begin
                if (!en_prev) begin edge_cnt = 0; ph = 0; end
                ph++;
                if (ph == HALF) begin
                    ph = 0;
                    ref_osc = ~ref_osc;
                    if (ref_osc) edge_cnt++;
                end
            end else if (wiggle) begin
                ref_osc = ~ref_osc;
            end else begin
                ref_osc = 1'b0;
            end
            en_prev = osc_en;
        end
    end

    // Port monitor.
    always @(negedge clk) begin
        if (!rst) begin
            if (osc_en && !m_en) begin
                en_rises++;
                osc_bits = pat[pidx];
                pidx = (pidx + 1) % 3;
            end
            if (latch_en && !m_lat) begin
                latch_rises++;
                chk(edge_cnt == THR, "R3 window opens at threshold", W'(edge_cnt), W'(THR));
            end
            if (!latch_en && m_lat) begin
                chk(edge_cnt == THR + 1, "R4 window closes next count", W'(edge_cnt), W'(THR + 1));
                chk(!osc_en, "R4 enable drops with window", W'(osc_en), W'(0));
            end
            if (resp_valid) vld_pulses++;
        end
        m_en  = osc_en;
        m_lat = latch_en;
    end

    task automatic run_capture(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [W-1:0] c, input logic [W-1:0] r,
                               input bit extra_start);
        logic [W-1:0] exp;
        int e0, l0, v0;
        exp = ((a & b) | (a & c) | (b & c)) ^ r;
        pat[0] = a; pat[1] = b; pat[2] = c; pidx = 0;
        rand_vec = r;
        e0 = en_rises; l0 = latch_rises; v0 = vld_pulses;
        @(posedge clk); #3 start = 1'b1;
        @(negedge clk);
        chk(!osc_en, "R2 enable low before start sampled", W'(osc_en), W'(0));
        @(posedge clk); #3 start = 1'b0;
        @(negedge clk);
        chk(osc_en, "R2 enable high after start", W'(osc_en), W'(1));
        if (extra_start) begin
            repeat (700) @(posedge clk);
            #3 start = 1'b1;
            @(posedge clk); #3 start = 1'b0;
        end
        while (!resp_valid) @(negedge clk);
        chk(resp == exp, "R6 R7 voted and whitened response", resp, exp);
        chk(!osc_en, "R7 enable low at strobe", W'(osc_en), W'(0));
        chk(en_rises - e0 == 3, "R5 enable periods per capture", W'(en_rises - e0), W'(3));
        chk(latch_rises - l0 == 3, "R5 capture windows per capture", W'(latch_rises - l0), W'(3));
        @(negedge clk);
        chk(!resp_valid, "R7 strobe one cycle", W'(resp_valid), W'(0));
        repeat (20) @(negedge clk);
        chk(resp == exp, "R7 response held", resp, exp);
        chk(vld_pulses - v0 == 1, "R8 single strobe per capture", W'(vld_pulses - v0), W'(1));
        chk(!osc_en, "R8 no restart after capture", W'(osc_en), W'(0));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!osc_en && !latch_en && !resp_valid && resp == '0, "R1 outputs during reset",
            {resp[W-4:0], osc_en, latch_en, resp_valid}, '0);
        @(posedge clk); #3 rst = 1'b0;
        @(negedge clk);
        chk(!osc_en && !latch_en && !resp_valid && resp == '0, "R1 outputs after reset",
            {resp[W-4:0], osc_en, latch_en, resp_valid}, '0);

        // Vector table walk (R6, R7, R10 full-width patterns).
        for (int i = 0; i < NVEC; i++) begin
            run_capture(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0);
        end

        // R8: start while busy is ignored.
        run_capture({W{1'b1}}, {30{4'h3}}, {30{4'hC}}, {10{12'h5A5}}, 1'b1);

        // R9: reference edges while idle do nothing.
        begin
            int e0, l0, v0;
            logic [W-1:0] held;
            e0 = en_rises; l0 = latch_rises; v0 = vld_pulses; held = resp;
            wiggle = 1'b1;
            repeat (700) @(posedge clk);
            #3 wiggle = 1'b0;
            repeat (10) @(negedge clk);
            chk(en_rises == e0 && !osc_en, "R9 no enable from idle edges", W'(en_rises - e0), W'(0));
            chk(latch_rises == l0, "R9 no window from idle edges", W'(latch_rises - l0), W'(0));
            chk(vld_pulses == v0 && resp == held, "R9 response untouched", resp, held);
        end

        // R2 again after idle activity: a fresh capture still works.
        run_capture({15{8'h81}}, {15{8'h18}}, {15{8'h99}}, {W{1'b1}}, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule